// File: doc/BRIEF.md
# LIN Slave Mode Control and Baud Divider Update Register

This block is the byte-wide control and status register for the LIN extension of a UART. Software reaches it over a small register bus with an address, write data, a write strobe and a combinational read port. The same bus also holds two software divider registers, low and high. The block stores the mode bits: master or slave role, automatic resynchronisation enable, header interrupt enable and divider update method. It also holds a header-detect flag and a sync-state flag. It drives the header interrupt and gives the receiver core the sync-state flag, so the receiver knows when to count falling edges on the receive line.

The block owns the working baud divider. The divider takes its value from one of two places. The first is the software divider registers, loaded either at once on a low-byte write or on the next received-character strobe after that write. The second is the measured divider reported by the receiver at the end of a sync field. A measured load clears the deferred-update mode bit by itself.

Top module: `lin_ctrl_reg`

## Requirements
- R1: After reset, the control byte, both software divider registers and the working divider read zero, and the interrupt output is low.
- R2: The control byte sits at address 0x9. Its bit layout is: bit 7 update method, bit 5 role (1 = slave), bit 4 resync enable, bit 2 interrupt enable, bit 1 header flag, bit 0 sync flag. Bits 6 and 3 always read 0. Bits 7, 5, 4 and 2 read back the value written.
- R3: The low divider byte is at address 0x2 and the high byte is at 0x3. The working divider is {high, low}. Writing the low byte while bit 7 is 0 loads {high, new low} into the working divider on the next cycle. Writing the high byte alone leaves the working divider unchanged. Both bytes read back.
- R4: Writing the low byte while bit 7 is 1 leaves the working divider unchanged. The divider loads {high, low} on the first received-character strobe in a later cycle. A strobe with no pending update has no effect.
- R5: A measured-divider strobe loads the measured value into the working divider on the next cycle, but only when the role is slave and resync is enabled. The same load clears bit 7 and cancels any pending deferred update. In any other mode the strobe has no effect.
- R6: When a measured load and an immediate low-byte load fall in the same cycle, the measured value wins.
- R7: Hardware sets the header flag on a header-complete strobe, only in slave mode. Writing 0 to bit 1 clears the flag. Writing 1 to bit 1 has no effect.
- R8: The interrupt output is high exactly when both the header flag and the interrupt enable are 1.
- R9: Hardware sets the sync flag on a break strobe, only in slave mode. A sync-done strobe clears it, and so does writing 0 to bit 0. Writing 1 to bit 0 has no effect.
- R10: When a hardware set and a software write-0 reach the same flag in the same cycle, the flag ends up set.
- R11: The sync_state, slave_mode and resync_en outputs always equal control bits 0, 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| brk_det | input | 1 | Break detected strobe from receiver |
| sync_done | input | 1 | Sync field analysis finished strobe |
| hdr_done | input | 1 | Full header received strobe |
| rx_char | input | 1 | Character received strobe |
| meas_valid | input | 1 | Measured divider valid strobe |
| meas_div | input | 16 | Measured divider value |
| hdr_irq | output | 1 | Header interrupt |
| sync_state | output | 1 | Sync flag, used by the receiver for edge counting |
| slave_mode | output | 1 | Role bit, 1 = slave |
| resync_en | output | 1 | Automatic resynchronisation enable |
| div_out | output | 16 | Working baud divider |

## Verification
The hardest case to reach is a pending deferred update that a measured load overrides. It needs slave role, resync enable and deferred mode all set, then a low-byte write, then a measured strobe, then a character strobe that must now do nothing. The vector table walks through that chain step by step and reads the divider after each step. The collision cases are reached by driving a strobe in the same cycle as the bus write that opposes it. These are a hardware flag set against a write of 0, a measured load against an immediate low-byte write, and a deferred write against a character strobe.

// File: rtl/lin_ctrl_pkg.sv
`timescale 1ns/1ps
package lin_ctrl_pkg;

    // Bit positions in the control byte; software decodes these.
    localparam int BIT_UPD    = 7;
    localparam int BIT_SLAVE  = 5;
    localparam int BIT_RESYNC = 4;
    localparam int BIT_IEN    = 2;
    localparam int BIT_HDR    = 1;
    localparam int BIT_SYNC   = 0;

    typedef struct packed {
        logic upd_mode;
        logic slave;
        logic resync;
        logic irq_en;
        logic hdr_flag;
        logic sync_flag;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '0;

endpackage

// File: rtl/lin_ctrl_bits.sv
`timescale 1ns/1ps
module lin_ctrl_bits
    import lin_ctrl_pkg::*;
#(
    parameter int             AW        = 4,
    parameter logic [AW-1:0]  CTRL_ADDR = 4'h9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          wr_en,
    input  logic          brk_det,
    input  logic          sync_done,
    input  logic          hdr_done,
    input  logic          meas_apply,
    output ctrl_state_t   state
);

    ctrl_state_t st_d, st_q;
    logic        ctrl_wr;

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_en && (addr == CTRL_ADDR);

        // Software writes go first; hardware events below take priority.
        if (ctrl_wr) begin
            st_d.upd_mode = wdata[BIT_UPD];
            st_d.slave    = wdata[BIT_SLAVE];
            st_d.resync   = wdata[BIT_RESYNC];
            st_d.irq_en   = wdata[BIT_IEN];
            if (!wdata[BIT_HDR])  st_d.hdr_flag  = 1'b0;
            if (!wdata[BIT_SYNC]) st_d.sync_flag = 1'b0;
        end

        if (sync_done)              st_d.sync_flag = 1'b0;
        if (st_q.slave && brk_det)  st_d.sync_flag = 1'b1;
        if (st_q.slave && hdr_done) st_d.hdr_flag  = 1'b1;

        // A measured divider load ends the deferred-update mode.
        if (meas_apply)             st_d.upd_mode  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTRL_RESET;
        else        st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/lin_div_ctrl.sv
`timescale 1ns/1ps
module lin_div_ctrl #(
    parameter int             AW      = 4,
    parameter int             DIV_W   = 16,
    parameter logic [AW-1:0]  LO_ADDR = 4'h2,
    parameter logic [AW-1:0]  HI_ADDR = 4'h3,
    localparam int            HI_W    = DIV_W - 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    input  logic             wr_en,
    input  logic             upd_mode,
    input  logic             slave,
    input  logic             resync,
    input  logic             rx_char,
    input  logic             meas_valid,
    input  logic [DIV_W-1:0] meas_div,
    output logic             meas_apply,
    output logic [DIV_W-1:0] div_out,
    output logic [7:0]       lo_val,
    output logic [HI_W-1:0]  hi_val
);

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [7:0]       lo;
        logic [DIV_W-1:0] work;
        logic             pending;
    } div_state_t;

    div_state_t ds_d, ds_q;
    logic       lo_wr, hi_wr;

    always_comb begin
        ds_d       = ds_q;
        lo_wr      = wr_en && (addr == LO_ADDR);
        hi_wr      = wr_en && (addr == HI_ADDR);
        meas_apply = meas_valid && slave && resync;

        if (hi_wr) ds_d.hi = wdata[HI_W-1:0];
        if (lo_wr) ds_d.lo = wdata;

        if (meas_apply) begin
            // The measured value overrides every software-driven load.
            ds_d.work    = meas_div;
            ds_d.pending = 1'b0;
        end else if (lo_wr && !upd_mode) begin
            ds_d.work    = {ds_q.hi, wdata};
            ds_d.pending = 1'b0;
        end else begin
            if (ds_q.pending && rx_char) begin
                ds_d.work    = {ds_q.hi, ds_q.lo};
                ds_d.pending = 1'b0;
            end
            if (lo_wr && upd_mode) ds_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ds_q <= '0;
        else        ds_q <= ds_d;
    end

    assign div_out = ds_q.work;
    assign lo_val  = ds_q.lo;
    assign hi_val  = ds_q.hi;

endmodule

// File: rtl/lin_ctrl_reg.sv
`timescale 1ns/1ps
module lin_ctrl_reg
    import lin_ctrl_pkg::*;
#(
    parameter int             AW        = 4,
    parameter int             DIV_W     = 16,
    parameter logic [AW-1:0]  CTRL_ADDR = 4'h9,
    parameter logic [AW-1:0]  LO_ADDR   = 4'h2,
    parameter logic [AW-1:0]  HI_ADDR   = 4'h3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_we,
    output logic [7:0]       bus_rdata,
    input  logic             brk_det,
    input  logic             sync_done,
    input  logic             hdr_done,
    input  logic             rx_char,
    input  logic             meas_valid,
    input  logic [DIV_W-1:0] meas_div,
    output logic             hdr_irq,
    output logic             sync_state,
    output logic             slave_mode,
    output logic             resync_en,
    output logic [DIV_W-1:0] div_out
);

    localparam int HI_W = DIV_W - 8;

    ctrl_state_t     ctrl_st;
    logic            meas_apply;
    logic [7:0]      lo_val;
    logic [HI_W-1:0] hi_val;
    logic [7:0]      ctrl_byte;

    lin_ctrl_bits #(
        .AW        (AW),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .wr_en      (bus_we),
        .brk_det    (brk_det),
        .sync_done  (sync_done),
        .hdr_done   (hdr_done),
        .meas_apply (meas_apply),
        .state      (ctrl_st)
    );

    lin_div_ctrl #(
        .AW      (AW),
        .DIV_W   (DIV_W),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .wr_en      (bus_we),
        .upd_mode   (ctrl_st.upd_mode),
        .slave      (ctrl_st.slave),
        .resync     (ctrl_st.resync),
        .rx_char    (rx_char),
        .meas_valid (meas_valid),
        .meas_div   (meas_div),
        .meas_apply (meas_apply),
        .div_out    (div_out),
        .lo_val     (lo_val),
        .hi_val     (hi_val)
    );

    always_comb begin
        ctrl_byte             = '0;
        ctrl_byte[BIT_UPD]    = ctrl_st.upd_mode;
        ctrl_byte[BIT_SLAVE]  = ctrl_st.slave;
        ctrl_byte[BIT_RESYNC] = ctrl_st.resync;
        ctrl_byte[BIT_IEN]    = ctrl_st.irq_en;
        ctrl_byte[BIT_HDR]    = ctrl_st.hdr_flag;
        ctrl_byte[BIT_SYNC]   = ctrl_st.sync_flag;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR)    bus_rdata = ctrl_byte;
        else if (bus_addr == LO_ADDR) bus_rdata = lo_val;
        else if (bus_addr == HI_ADDR) bus_rdata[HI_W-1:0] = hi_val;
    end

    assign hdr_irq    = ctrl_st.hdr_flag & ctrl_st.irq_en;
    assign sync_state = ctrl_st.sync_flag;
    assign slave_mode = ctrl_st.slave;
    assign resync_en  = ctrl_st.resync;

endmodule

// File: rtl/lin_ctrl_sva.sv
`timescale 1ns/1ps
module lin_ctrl_sva #(
    parameter int             AW        = 4,
    parameter int             DIV_W     = 16,
    parameter logic [AW-1:0]  CTRL_ADDR = 4'h9,
    parameter logic [AW-1:0]  LO_ADDR   = 4'h2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_we,
    input logic [1:0]       rsv_bits,
    input logic             brk_det,
    input logic             hdr_done,
    input logic             rx_char,
    input logic             meas_valid,
    input logic [DIV_W-1:0] meas_div,
    input logic             hdr_irq,
    input logic             sync_state,
    input logic             slave_mode,
    input logic             resync_en,
    input logic [DIV_W-1:0] div_out,
    input logic             upd_mode,
    input logic             irq_en,
    input logic             hdr_flag
);

    // R2: reserved bits of the control byte read zero
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_ADDR) |-> (rsv_bits == 2'b00));

    // R3: no load source active means the working divider holds
    assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_we && bus_addr == LO_ADDR) && !rx_char && !meas_valid) |=> $stable(div_out));

    // R5: an applied measured divider appears next cycle and ends deferred mode
    assert_meas_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && slave_mode && resync_en) |=> (div_out == $past(meas_div) && !upd_mode));

    // R7: the header flag only rises after a header strobe in slave mode
    assert_hdr_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_flag) |-> $past(slave_mode && hdr_done));

    // R8: the interrupt only rises when enabled
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_irq) |-> irq_en);

    // R9 and R10: a break in slave mode always leaves the sync flag set
    assert_sync_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && brk_det) |=> sync_state);

    // R10: a header strobe in slave mode wins over any write
    assert_hdr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && hdr_done) |=> hdr_flag);

endmodule

bind lin_ctrl_reg lin_ctrl_sva #(
    .AW        (AW),
    .DIV_W     (DIV_W),
    .CTRL_ADDR (CTRL_ADDR),
    .LO_ADDR   (LO_ADDR)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .rsv_bits   ({bus_rdata[6], bus_rdata[3]}),
    .brk_det    (brk_det),
    .hdr_done   (hdr_done),
    .rx_char    (rx_char),
    .meas_valid (meas_valid),
    .meas_div   (meas_div),
    .hdr_irq    (hdr_irq),
    .sync_state (sync_state),
    .slave_mode (slave_mode),
    .resync_en  (resync_en),
    .div_out    (div_out),
    .upd_mode   (ctrl_st.upd_mode),
    .irq_en     (ctrl_st.irq_en),
    .hdr_flag   (ctrl_st.hdr_flag)
);

// File: tb/tb_lin_ctrl_reg.sv
`timescale 1ns/1ps
module tb_lin_ctrl_reg;

    localparam logic [3:0] A_CTRL = 4'h9;
    localparam logic [3:0] A_LO   = 4'h2;
    localparam logic [3:0] A_HI   = 4'h3;
    localparam int NVEC = 25;

    // {addr, wdata, we, events{brk,sdone,hdone,rx,mval}, meas_div, exp_ctrl, exp_div}
    localparam logic [57:0] VECS [NVEC] = '{
        {4'h3, 8'h12, 1'b1, 5'b00000, 16'h0000, 8'h00, 16'h0000},
        {4'h2, 8'h34, 1'b1, 5'b00000, 16'h0000, 8'h00, 16'h1234},
        {4'h9, 8'hFF, 1'b1, 5'b00000, 16'h0000, 8'hB4, 16'h1234},
        {4'h2, 8'h56, 1'b1, 5'b00000, 16'h0000, 8'hB4, 16'h1234},
        {4'h0, 8'h00, 1'b0, 5'b00010, 16'h0000, 8'hB4, 16'h1256},
        {4'h0, 8'h00, 1'b0, 5'b00010, 16'h0000, 8'hB4, 16'h1256},
        {4'h0, 8'h00, 1'b0, 5'b10000, 16'h0000, 8'hB5, 16'h1256},
        {4'h0, 8'h00, 1'b0, 5'b00100, 16'h0000, 8'hB7, 16'h1256},
        {4'h0, 8'h00, 1'b0, 5'b01000, 16'h0000, 8'hB6, 16'h1256},
        {4'h0, 8'h00, 1'b0, 5'b00001, 16'h0ABC, 8'h36, 16'h0ABC},
        {4'h9, 8'h34, 1'b1, 5'b00000, 16'h0000, 8'h34, 16'h0ABC},
        {4'h9, 8'hB4, 1'b1, 5'b00000, 16'h0000, 8'hB4, 16'h0ABC},
        {4'h2, 8'h77, 1'b1, 5'b00000, 16'h0000, 8'hB4, 16'h0ABC},
        {4'h0, 8'h00, 1'b0, 5'b00001, 16'h0F0F, 8'h34, 16'h0F0F},
        {4'h0, 8'h00, 1'b0, 5'b00010, 16'h0000, 8'h34, 16'h0F0F},
        {4'h2, 8'h88, 1'b1, 5'b00001, 16'h0321, 8'h34, 16'h0321},
        {4'h9, 8'h24, 1'b1, 5'b00000, 16'h0000, 8'h24, 16'h0321},
        {4'h0, 8'h00, 1'b0, 5'b00001, 16'h0555, 8'h24, 16'h0321},
        {4'h2, 8'h99, 1'b1, 5'b00000, 16'h0000, 8'h24, 16'h1299},
        {4'h9, 8'h04, 1'b1, 5'b00000, 16'h0000, 8'h04, 16'h1299},
        {4'h0, 8'h00, 1'b0, 5'b10100, 16'h0000, 8'h04, 16'h1299},
        {4'h9, 8'h24, 1'b1, 5'b00000, 16'h0000, 8'h24, 16'h1299},
        {4'h9, 8'h24, 1'b1, 5'b10000, 16'h0000, 8'h25, 16'h1299},
        {4'h9, 8'h25, 1'b1, 5'b00100, 16'h0000, 8'h27, 16'h1299},
        {4'h9, 8'h24, 1'b1, 5'b00000, 16'h0000, 8'h24, 16'h1299}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        brk_det = 1'b0, sync_done = 1'b0, hdr_done = 1'b0;
    logic        rx_char = 1'b0, meas_valid = 1'b0;
    logic [15:0] meas_div = '0;
    logic        hdr_irq, sync_state, slave_mode, resync_en;
    logic [15:0] div_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lin_ctrl_reg dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .brk_det    (brk_det),
        .sync_done  (sync_done),
        .hdr_done   (hdr_done),
        .rx_char    (rx_char),
        .meas_valid (meas_valid),
        .meas_div   (meas_div),
        .hdr_irq    (hdr_irq),
        .sync_state (sync_state),
        .slave_mode (slave_mode),
        .resync_en  (resync_en),
        .div_out    (div_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int idx);
        case (idx)
            0, 1:          return "R3";
            2:             return "R2";
            3, 4, 5:       return "R4";
            6, 8:          return "R9";
            7:             return "R7";
            9, 13, 14, 17: return "R5";
            10:            return "R7";
            11, 12:        return "R4";
            15:            return "R6";
            16:            return "R2";
            18:            return "R3";
            19, 21:        return "R11";
            20:            return "R9";
            22, 23:        return "R10";
            default:       return "R9";
        endcase
    endfunction

    // Drive one cycle of stimulus, then park on the control address for reading.
    task automatic step(input logic [3:0] a, input logic [7:0] d, input logic we,
                        input logic [4:0] ev, input logic [15:0] md);
        @(negedge clk);
        bus_addr  = a;  bus_wdata = d;  bus_we = we;
        {brk_det, sync_done, hdr_done, rx_char, meas_valid} = ev;
        meas_div  = md;
        @(posedge clk);
        #2;
        bus_we = 1'b0;
        {brk_det, sync_done, hdr_done, rx_char, meas_valid} = 5'b0;
        meas_div = '0;
        bus_addr = A_CTRL;
        #1;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = A_CTRL;
        #1;
    endtask

    task automatic check_reset_state(input string tag);
        logic [7:0] v;
        read_reg(A_CTRL, v); check("R1", {tag, " ctrl"}, 32'(v), 32'h00);
        read_reg(A_LO, v);   check("R1", {tag, " lo"},   32'(v), 32'h00);
        read_reg(A_HI, v);   check("R1", {tag, " hi"},   32'(v), 32'h00);
        check("R1", {tag, " div"}, 32'(div_out), 32'h0);
        check("R1", {tag, " irq"}, 32'(hdr_irq), 32'h0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #3;
        check_reset_state("initial reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #3;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [57:0] vec;
            logic [7:0]  ec;
            vec = VECS[i];
            step(vec[57:54], vec[53:46], vec[45], vec[44:40], vec[39:24]);
            ec = vec[23:16];
            read_reg(A_CTRL, v);
            check(req_of(i), $sformatf("vec %0d ctrl", i), 32'(v), 32'(ec));
            check(req_of(i), $sformatf("vec %0d div", i), 32'(div_out), 32'(vec[15:0]));
            check("R8",  $sformatf("vec %0d irq", i), 32'(hdr_irq), 32'(ec[1] & ec[2]));
            check("R11", $sformatf("vec %0d sync_state", i), 32'(sync_state), 32'(ec[0]));
            check("R11", $sformatf("vec %0d slave", i), 32'(slave_mode), 32'(ec[5]));
            check("R11", $sformatf("vec %0d resync", i), 32'(resync_en), 32'(ec[4]));
        end

        // R3: both software divider bytes read back
        read_reg(A_LO, v); check("R3", "lo readback", 32'(v), 32'h99);
        read_reg(A_HI, v); check("R3", "hi readback", 32'(v), 32'h12);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #5;
        check_reset_state("mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R4: a strobe in the same cycle as a deferred write does not load it
        step(A_CTRL, 8'h80, 1'b1, 5'b00000, 16'h0);
        step(A_HI,   8'h01, 1'b1, 5'b00000, 16'h0);
        step(A_LO,   8'h02, 1'b1, 5'b00010, 16'h0);
        check("R4", "strobe with deferred write", 32'(div_out), 32'h0000);
        step(4'h0, 8'h00, 1'b0, 5'b00010, 16'h0);
        check("R4", "later strobe loads", 32'(div_out), 32'h0102);

        // R5: measured strobe in master mode with resync on has no effect
        step(A_CTRL, 8'h10, 1'b1, 5'b00000, 16'h0);
        step(4'h0, 8'h00, 1'b0, 5'b00001, 16'h4444);
        check("R5", "measured ignored in master", 32'(div_out), 32'h0102);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule